// File: doc/BRIEF.md
# Delay Line Unit Calibration Sequencer

This block calibrates a tapped delay line. It finds the smallest unit-delay setting at which the line, measured against one period of the input clock, reports a usable length. From the length it derives how many phase taps can be used. The sequencer drives the delay line's configuration port: a unit value, a tap select, a sample-enable and a write strobe. It reads back a length word and a flag that marks the length as valid.

Calibration begins with a start pulse while the block is idle. The block tries the unit values in rising order from zero, one write per trial. During every trial it forces the tap select to the value one past the last tap and holds sample-enable high. For each trial it waits a bounded number of cycles for a valid length. It accepts the first length that is nonzero and has no bit set at or above the tap count. The accepted unit and the index of the highest set bit of that length stay on the result ports until the next start. If no unit value is accepted, the run ends with an error pulse.

Top module: `dly_unit_cal`

## Requirements
- R1: A start pulse while idle begins a sweep at unit 0. Each trial issues exactly one single-cycle `cfg_wr_o` pulse with `cfg_unit_o` at the trial's unit value, and the value rises by one per trial up to 127.
- R2: While calibrating, `cfg_sel_o` equals NTAPS+1 (12 by default) and `cfg_sen_o` is 1. While idle, both are 0.
- R3: After each write, the block waits up to TIMEOUT cycles for `len_vld_i`. If the flag does not arrive in that window, the block moves to the next unit value without accepting.
- R4: A valid length is accepted only when it is nonzero and bits 11 and above are clear (value below 2^11). Any other valid length moves the sweep to the next unit value.
- R5: On acceptance, `done_o` pulses high for one cycle. In the same cycle `res_unit_o` shows the trial's unit value and `res_phase_o` shows the bit position of the highest set bit of the accepted length.
- R6: If all 128 unit values are tried without acceptance, `err_o` pulses high for one cycle, `done_o` stays low and the result ports read 0.
- R7: A start pulse during a calibration is ignored: the sweep continues without restarting.
- R8: The result ports are cleared to 0 by a start. Otherwise they hold their value while idle.
- R9: After reset the block is idle, and `done_o`, `err_o`, `cfg_wr_o`, `cfg_sen_o`, `cfg_sel_o` and the result ports are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin calibration (pulse, honoured when idle) |
| done_o | output | 1 | One-cycle pulse: a unit value was accepted |
| err_o | output | 1 | One-cycle pulse: every unit value was rejected |
| res_unit_o | output | 7 | Accepted unit value |
| res_phase_o | output | 4 | Maximum phase index (highest set bit of the length) |
| cfg_wr_o | output | 1 | Configuration write strobe to the delay line |
| cfg_unit_o | output | 7 | Unit value being tried |
| cfg_sel_o | output | 4 | Tap select |
| cfg_sen_o | output | 1 | Sample enable |
| len_i | input | 12 | Measured length word |
| len_vld_i | input | 1 | Length word valid |

## Verification
A behavioural delay-line model in the bench answers each trial from a per-unit table: a response delay or no response at all, and a length word. Directed tables separate the acceptance edges: length 1 against 0, 2047 against 2048 and 4095, and silent units that must time out rather than stall. Sweeps with no acceptable unit must reach 127 and raise the error. Random tables with a fixed seed mix these rejections before an accepted unit placed at random. Against these, the write count, the unit order, the chosen unit and the phase index are checked. A start issued in the middle of a sweep and a long idle wait after a result test that a run is not restarted and that results are held.

// File: rtl/dly_unit_cal.sv
module dly_unit_cal #(
  parameter int UNIT_W  = 7,
  parameter int SEL_W   = 4,
  parameter int LEN_W   = 12,
  parameter int NTAPS   = 11,
  parameter int TIMEOUT = 125000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              done_o,
  output logic              err_o,
  output logic [UNIT_W-1:0] res_unit_o,
  output logic [$clog2(LEN_W)-1:0] res_phase_o,
  output logic              cfg_wr_o,
  output logic [UNIT_W-1:0] cfg_unit_o,
  output logic [SEL_W-1:0]  cfg_sel_o,
  output logic              cfg_sen_o,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              len_vld_i
);

  localparam int PH_W     = $clog2(LEN_W);
  localparam int TMO_W    = $clog2(TIMEOUT + 1);
  localparam int UNIT_MAX = (1 << UNIT_W) - 1;
  localparam int SEL_CAL  = NTAPS + 1;

  typedef enum logic [1:0] {S_IDLE, S_WR, S_WAIT} st_t;

  st_t               st;
  logic [UNIT_W-1:0] unit;
  logic [TMO_W-1:0]  tmo;
  logic              hit;
  logic              last_unit;
  logic              tmo_end;
  logic [PH_W-1:0]   msb;

  always_comb begin
    msb = '0;
    for (int i = 0; i < LEN_W; i++)
      if (len_i[i]) msb = PH_W'(i);
  end

  assign hit       = (len_i != '0) && ((len_i >> NTAPS) == '0);
  assign last_unit = (unit == UNIT_W'(UNIT_MAX));
  assign tmo_end   = (tmo == TMO_W'(TIMEOUT - 1));

  assign cfg_wr_o   = (st == S_WR);
  assign cfg_unit_o = unit;
  assign cfg_sen_o  = (st != S_IDLE);
  assign cfg_sel_o  = cfg_sen_o ? SEL_W'(SEL_CAL) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      unit        <= '0;
      tmo         <= '0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      res_unit_o  <= '0;
      res_phase_o <= '0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          unit        <= '0;
          res_unit_o  <= '0;
          res_phase_o <= '0;
          st          <= S_WR;
        end
        S_WR: begin
          tmo <= '0;
          st  <= S_WAIT;
        end
        S_WAIT: begin
          if (len_vld_i && hit) begin
            done_o      <= 1'b1;
            res_unit_o  <= unit;
            res_phase_o <= msb;
            st          <= S_IDLE;
          end else if (len_vld_i || tmo_end) begin
            if (last_unit) begin
              err_o <= 1'b1;
              st    <= S_IDLE;
            end else begin
              unit <= unit + 1'b1;
              st   <= S_WR;
            end
          end else begin
            tmo <= tmo + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_o && $past(st == S_WAIT)) |-> (cfg_unit_o == $past(cfg_unit_o) + 1'b1));

  // R1
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_o |=> !cfg_wr_o);

  // R2
  sweep_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_o |-> (cfg_sen_o && cfg_sel_o == SEL_W'(SEL_CAL)));

  // R3
  tmo_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |-> (tmo < TMO_W'(TIMEOUT)));

  // R5
  done_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (res_phase_o < PH_W'(NTAPS)));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6
  end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  // R8
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st == S_IDLE) && !$past(start_i)) |-> $stable(res_unit_o));

endmodule

// File: tb/dly_unit_cal_tb.sv
module dly_unit_cal_tb;
  localparam int TMO = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        done_o, err_o, cfg_wr_o, cfg_sen_o;
  logic [6:0]  res_unit_o, cfg_unit_o;
  logic [3:0]  res_phase_o, cfg_sel_o;
  logic [11:0] len_i = '0;
  logic        len_vld_i = 1'b0;

  int checks = 0;
  int errors = 0;

  int          dly  [128];
  logic [11:0] lenv [128];

  int   wr_cnt = 0;
  bit   order_bad = 0;
  bit   sel_bad = 0;
  bit   pending = 0;
  int   cnt = 0;
  int   cur = 0;

  always #4 clk = ~clk;

  dly_unit_cal #(.TIMEOUT(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .done_o(done_o), .err_o(err_o),
    .res_unit_o(res_unit_o), .res_phase_o(res_phase_o),
    .cfg_wr_o(cfg_wr_o), .cfg_unit_o(cfg_unit_o),
    .cfg_sel_o(cfg_sel_o), .cfg_sen_o(cfg_sen_o),
    .len_i(len_i), .len_vld_i(len_vld_i)
  );

  always @(negedge clk) begin
    if (cfg_wr_o) begin
      if (int'(cfg_unit_o) != wr_cnt) order_bad = 1;
      if (cfg_sel_o != 4'd12 || !cfg_sen_o) sel_bad = 1;
      wr_cnt++;
      cur = int'(cfg_unit_o);
      cnt = 0;
      pending = (dly[cur] != 0);
      len_vld_i = 1'b0;
    end else if (pending) begin
      cnt++;
      if (cnt == dly[cur]) begin
        len_vld_i = 1'b1;
        len_i = lenv[cur];
        pending = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit ok_len(input int u);
    return dly[u] != 0 && lenv[u] != 0 && lenv[u] < 12'd2048;
  endfunction

  function automatic int msb_of(input logic [11:0] v);
    int m = 0;
    for (int i = 0; i < 12; i++) if (v[i]) m = i;
    return m;
  endfunction

  function automatic int exp_unit();
    for (int u = 0; u < 128; u++) if (ok_len(u)) return u;
    return -1;
  endfunction

  task automatic fill_reject(input int u);
    int k = int'($urandom_range(0, 3));
    dly[u] = int'($urandom_range(1, 8));
    case (k)
      0: dly[u] = 0;
      1: lenv[u] = 12'd0;
      2: lenv[u] = 12'd2048 + 12'($urandom_range(0, 2047));
      default: lenv[u] = 12'hFFF;
    endcase
  endtask

  task automatic run_case(input string name, input bit mid_start);
    int eu = exp_unit();
    int ep = (eu >= 0) ? msb_of(lenv[eu]) : 0;
    int n = 0;
    bit fin = 0;
    @(negedge clk);
    wr_cnt = 0; order_bad = 0; sel_bad = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(res_unit_o == 0 && res_phase_o == 0, {"R8 clear on start ", name}, int'(res_unit_o), 0);
    while (!fin && n < 20000) begin
      if (done_o || err_o) fin = 1;
      else begin
        if (mid_start && n == 10) start_i = 1'b1;
        if (mid_start && n == 11) start_i = 1'b0;
        @(negedge clk);
        n++;
      end
    end
    chk(fin, {"R3 run ends ", name}, n, 0);
    if (eu >= 0) begin
      chk(done_o && !err_o, {"R5 done ", name}, int'(done_o), 1);
      chk(int'(res_unit_o) == eu, {"R5 unit ", name}, int'(res_unit_o), eu);
      chk(int'(res_phase_o) == ep, {"R5 phase ", name}, int'(res_phase_o), ep);
      chk(wr_cnt == eu + 1, {"R4 trial count ", name}, wr_cnt, eu + 1);
    end else begin
      chk(err_o && !done_o, {"R6 error ", name}, int'(err_o), 1);
      chk(res_unit_o == 0 && res_phase_o == 0, {"R6 result zero ", name}, int'(res_unit_o), 0);
      chk(wr_cnt == 128, {"R6 trial count ", name}, wr_cnt, 128);
    end
    chk(!order_bad, {"R1 unit order ", name}, int'(order_bad), 0);
    if (mid_start) chk(!order_bad, {"R7 start ignored ", name}, int'(order_bad), 0);
    chk(!sel_bad, {"R2 sweep config ", name}, int'(sel_bad), 0);
    @(negedge clk);
    chk(!done_o && !err_o, {"R5 single pulse ", name}, int'(done_o | err_o), 0);
    chk(!cfg_sen_o && cfg_sel_o == 0, {"R2 idle config ", name}, int'(cfg_sel_o), 0);
    repeat (20) @(negedge clk);
    chk(int'(res_unit_o) == ((eu >= 0) ? eu : 0), {"R8 hold ", name}, int'(res_unit_o), (eu >= 0) ? eu : 0);
  endtask

  task automatic clear_tab();
    for (int u = 0; u < 128; u++) begin
      dly[u] = 2;
      lenv[u] = 12'hFFF;
    end
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    clear_tab();
    repeat (3) @(negedge clk);
    chk(!done_o && !err_o && !cfg_wr_o && !cfg_sen_o && cfg_sel_o == 0
        && res_unit_o == 0 && res_phase_o == 0, "R9 reset state", int'(cfg_sen_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!cfg_wr_o && !cfg_sen_o, "R9 idle after reset", int'(cfg_wr_o), 0);

    clear_tab(); lenv[0] = 12'd1;
    run_case("len1 at unit0", 0);

    clear_tab();
    lenv[0] = 12'd0; lenv[1] = 12'd2048; lenv[2] = 12'd4095; lenv[3] = 12'd2047;
    run_case("edge 2047", 0);

    clear_tab();
    for (int u = 0; u < 6; u++) dly[u] = 0;
    lenv[6] = 12'h0A0; dly[6] = 8;
    run_case("R3 silent units", 0);

    clear_tab();
    run_case("all reject", 0);

    clear_tab();
    for (int u = 0; u < 128; u++) dly[u] = 0;
    run_case("all silent", 0);

    clear_tab();
    lenv[40] = 12'h3F; dly[40] = 3;
    run_case("R7 mid start", 1);

    for (int t = 0; t < 10; t++) begin
      int a = int'($urandom_range(0, 140));
      for (int u = 0; u < 128; u++) begin
        if (u < a) fill_reject(u);
        else begin
          dly[u] = int'($urandom_range(1, 8));
          lenv[u] = 12'($urandom_range(1, 2047));
        end
      end
      run_case("random", 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule